// File: doc/BRIEF.md
# Command-Driven SPI Master Frame Engine

This block is an SPI master that runs one frame for each 32-bit command word. The word says what to send and which chip-select lines to drive low. It also picks one of a few static attribute sets, which give the frame length, clock polarity and phase, the SCK rate and the select-to-clock delays. Further bits in the word can do four things:
- keep the selects low after the frame;
- put an even or odd parity bit in the last bit slot, and check parity on what comes back;
- mark the frame as the end of a queue;
- zero the frame counter before the frame starts.

Commands enter on a valid/ready stream. `cmd_ready_o` is high only while the engine has no frame in progress and no halt is pending. A word counts as taken on a clock edge where valid and ready are both high. Received words leave on a second valid/ready stream. A word stays on `rx_data_o`, unchanged, until the consumer takes it. If the next frame finishes while that word is still waiting, the engine pauses after that frame's last SCK edge and loses nothing. Status pins (sticky flags, counter, halt, flag clear) are plain levels.

Top module: `spi_cmd_master`

## Requirements
- R1: Command word fields, by bit of `cmd_data_i[31:0]`:
  - [31]: keep-select.
  - [30:28]: attribute index.
  - [27]: end-of-queue.
  - [26]: counter clear.
  - [25]: parity enable.
  - [24]: parity odd (1) or even (0).
  - [23-i]: select for chip-select line i, for i from 0 to 7.
  - [15:0]: data.
- R2: A frame of N bits (N from the chosen set, clamped to 4..16) has exactly 2N SCK edges. SCK idles at the set's polarity. MOSI carries the low N data bits MSB first. MISO is sampled on the first edge of each bit when phase=0 and on the second edge when phase=1. `rx_data_o` holds the N received bits, right-aligned.
- R3: An attribute index at or above NUM_ATTR selects set 0.
- R4: During a frame, `cs_n_o[i]` is low exactly when line i's select bit is 1. The first SCK edge comes lead+div+1 clocks after the selects assert. The frame completes trail+2 clocks after the last SCK edge, provided the receive slot is free.
- R5: With keep-select at 1, the selects stay low after the frame, including while no command waits. They return high when a frame with keep-select at 0 completes, or on the clock after `halt_i` while the engine holds them.
- R6: With parity enabled, the last bit slot carries a parity bit in place of data bit 0. That bit makes the count of ones in the N transmitted bits even (polarity 0) or odd (polarity 1).
- R7: With parity enabled, a received frame whose count of ones does not match the polarity sets `rx_perr_o` with that word and sets the sticky `perr_flag_o`.
- R8: Completing a frame with end-of-queue at 1 sets the sticky `eoq_flag_o`. Writing 1 to `flag_clr_i[0]` clears the end-of-queue flag and writing 1 to `flag_clr_i[1]` clears the parity-error flag. A set in the same cycle wins over the clear.
- R9: `xfer_cnt_o` adds one per completed frame and wraps at its maximum. A counter clear zeroes it when the frame is accepted, so that frame ends with a count of 1.
- R10: `rx_data_o` and `rx_perr_o` stay stable while `rx_valid_o` is high and `rx_ready_i` is low. A later frame stalls and does not overwrite them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Engine can take a command |
| cmd_data_i | input | 32 | Command word |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Consumer takes the received word |
| rx_data_o | output | 16 | Received bits, right-aligned |
| rx_perr_o | output | 1 | Parity mismatch for this word |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NCS | Active-low chip selects |
| halt_i | input | 1 | Release selects held by keep-select |
| flag_clr_i | input | 2 | Write-1 clear: [0] end-of-queue, [1] parity error |
| eoq_flag_o | output | 1 | Sticky end-of-queue flag |
| perr_flag_o | output | 1 | Sticky parity-error flag |
| xfer_cnt_o | output | CNT_W | Completed frame counter |
| attr_size_i | input | NUM_ATTR*5 | Frame size per set |
| attr_cpol_i | input | NUM_ATTR | Clock polarity per set |
| attr_cpha_i | input | NUM_ATTR | Clock phase per set |
| attr_div_i | input | NUM_ATTR*8 | SCK half-period in clocks per set (0 acts as 1) |
| attr_lead_i | input | NUM_ATTR*8 | Select-to-first-edge delay per set |
| attr_trail_i | input | NUM_ATTR*8 | Last-edge-to-completion delay per set |

## Verification
The hardest case to reach is a stall after the last SCK edge. It needs one received word to sit unread while a second frame runs to its end. The bench gets there by holding `rx_ready_i` low across two frames. It then checks that the engine refuses commands and that the first word is unchanged. It then releases ready and checks that the second word replaces the first on the very next clock. A sweep of every clock mode, four frame sizes and all three parity settings covers both sample phases and the parity bit at every frame length. A small counter width lets the sweep wrap the counter.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef struct packed {
    logic       keep;
    logic [2:0] aidx;
    logic       eoq;
    logic       clr;
    logic       pen;
    logic       podd;
    logic [7:0] sel;
    logic [15:0] data;
  } cmd_t;

  typedef struct packed {
    logic [4:0] size;
    logic       cpol;
    logic       cpha;
    logic [7:0] div;
    logic [7:0] lead;
    logic [7:0] trail;
  } attr_t;

  function automatic logic [4:0] clamp_size(input logic [4:0] s);
    if (s < 5'd4)       return 5'd4;
    else if (s > 5'd16) return 5'd16;
    else                return s;
  endfunction

endpackage

// File: rtl/spi_attr_pick.sv
module spi_attr_pick
  import spi_cmd_pkg::*;
#(
  parameter int NUM_ATTR = 2
) (
  input  logic [NUM_ATTR*5-1:0] size_i,
  input  logic [NUM_ATTR-1:0]   cpol_i,
  input  logic [NUM_ATTR-1:0]   cpha_i,
  input  logic [NUM_ATTR*8-1:0] div_i,
  input  logic [NUM_ATTR*8-1:0] lead_i,
  input  logic [NUM_ATTR*8-1:0] trail_i,
  input  logic [2:0]            idx_i,
  output attr_t                 attr_o
);
  attr_t sets [NUM_ATTR];

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_set
    assign sets[g].size  = size_i[g*5 +: 5];
    assign sets[g].cpol  = cpol_i[g];
    assign sets[g].cpha  = cpha_i[g];
    assign sets[g].div   = div_i[g*8 +: 8];
    assign sets[g].lead  = lead_i[g*8 +: 8];
    assign sets[g].trail = trail_i[g*8 +: 8];
  end

  // Unimplemented indices fall through to set 0 (R3)
  always_comb begin
    attr_o = sets[0];
    for (int k = 1; k < NUM_ATTR; k++)
      if (idx_i == k[2:0]) attr_o = sets[k];
  end
endmodule

// File: rtl/spi_parity_unit.sv
module spi_parity_unit (
  input  logic [15:0] data_i,
  input  logic [4:0]  nbits_i,
  input  logic        pen_i,
  input  logic        podd_i,
  output logic [15:0] tx_aligned_o,
  input  logic [15:0] rx_i,
  input  logic        rx_pen_i,
  input  logic        rx_podd_i,
  output logic        rx_err_o
);
  logic [4:0]  pad;
  logic [15:0] mask, low, word;
  logic        pbit;

  always_comb begin
    pad  = 5'd16 - nbits_i;
    mask = 16'hFFFF >> pad;
    low  = data_i & mask;
    pbit = (^(low >> 1)) ^ podd_i;  // R6
    word = pen_i ? {low[15:1], pbit} : low;
    tx_aligned_o = word << pad;
  end

  assign rx_err_o = rx_pen_i & ((^rx_i) ^ rx_podd_i);  // R7
endmodule

// File: rtl/spi_frame_core.sv
module spi_frame_core
  import spi_cmd_pkg::*;
#(
  parameter int NCS = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  output logic           cmd_ready_o,
  input  cmd_t           cmd_i,
  input  attr_t          attr_i,
  input  logic           halt_i,
  input  logic           rx_ready_i,
  output logic           rx_valid_o,
  output logic [15:0]    rx_data_o,
  output logic           rx_perr_o,
  output logic           sck_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_n_o,
  output logic           start_clr_o,
  output logic           done_o,
  output logic           done_eoq_o,
  output logic           perr_pulse_o
);
  localparam int EW = 6;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_LEAD, S_SHIFT, S_DONE, S_TRAIL} st_t;

  st_t             st;
  logic [NCS-1:0]  cs_n_q, sel_n;
  logic            sck_q, cpha_q, keep_q, eoq_q, pen_q, podd_q;
  logic [15:0]     txsr, rxsr, tx_aligned, rx_data_q;
  logic [7:0]      dly, hc, div_m1_q, trail_q;
  logic [EW-1:0]   edge_q, last_e;
  logic [4:0]      nbits_q, nbits_new;
  logic            rx_valid_q, rx_perr_q, rx_err, slot_free, accept;
  logic            samp, shift_tx;

  assign nbits_new = clamp_size(attr_i.size);

  always_comb
    for (int i = 0; i < NCS; i++) sel_n[i] = ~cmd_i.sel[7-i];  // R1, R4

  spi_parity_unit u_par (
    .data_i      (cmd_i.data),
    .nbits_i     (nbits_new),
    .pen_i       (cmd_i.pen),
    .podd_i      (cmd_i.podd),
    .tx_aligned_o(tx_aligned),
    .rx_i        (rxsr),
    .rx_pen_i    (pen_q),
    .rx_podd_i   (podd_q),
    .rx_err_o    (rx_err)
  );

  assign cmd_ready_o  = (st == S_IDLE) || (st == S_HOLD && !halt_i);
  assign accept       = cmd_valid_i && cmd_ready_o;
  assign slot_free    = !rx_valid_q || rx_ready_i;
  assign last_e       = {nbits_q, 1'b0} - 6'd1;
  assign samp         = cpha_q ? edge_q[0] : ~edge_q[0];
  assign shift_tx     = cpha_q ? (~edge_q[0] && edge_q != '0) : (edge_q[0] && edge_q != last_e);
  assign start_clr_o  = accept && cmd_i.clr;
  assign done_o       = (st == S_TRAIL) && (dly == '0);
  assign done_eoq_o   = eoq_q;
  assign perr_pulse_o = (st == S_DONE) && slot_free && rx_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; cs_n_q <= '1; sck_q <= 1'b0; cpha_q <= 1'b0;
      keep_q <= 1'b0; eoq_q <= 1'b0; pen_q <= 1'b0; podd_q <= 1'b0;
      txsr <= '0; rxsr <= '0; dly <= '0; hc <= '0; div_m1_q <= '0;
      trail_q <= '0; edge_q <= '0; nbits_q <= 5'd4;
      rx_valid_q <= 1'b0; rx_data_q <= '0; rx_perr_q <= 1'b0;
    end else begin
      if (rx_valid_q && rx_ready_i) rx_valid_q <= 1'b0;
      unique case (st)
        S_IDLE, S_HOLD: begin
          if (st == S_HOLD && halt_i) begin
            cs_n_q <= '1;
            st     <= S_IDLE;
          end else if (accept) begin
            cs_n_q   <= sel_n;
            sck_q    <= attr_i.cpol;
            cpha_q   <= attr_i.cpha;
            nbits_q  <= nbits_new;
            div_m1_q <= (attr_i.div == '0) ? 8'd0 : attr_i.div - 8'd1;
            trail_q  <= attr_i.trail;
            dly      <= attr_i.lead;
            keep_q   <= cmd_i.keep;
            eoq_q    <= cmd_i.eoq;
            pen_q    <= cmd_i.pen;
            podd_q   <= cmd_i.podd;
            txsr     <= tx_aligned;
            rxsr     <= '0;
            edge_q   <= '0;
            st       <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (dly == '0) begin
            hc <= div_m1_q;
            st <= S_SHIFT;
          end else dly <= dly - 8'd1;
        end
        S_SHIFT: begin
          if (hc == '0) begin
            hc     <= div_m1_q;
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 6'd1;
            if (samp)     rxsr <= {rxsr[14:0], miso_i};
            if (shift_tx) txsr <= {txsr[14:0], 1'b0};
            if (edge_q == last_e) st <= S_DONE;
          end else hc <= hc - 8'd1;
        end
        S_DONE: begin
          if (slot_free) begin
            rx_valid_q <= 1'b1;
            rx_data_q  <= rxsr;
            rx_perr_q  <= rx_err;
            dly        <= trail_q;
            st         <= S_TRAIL;
          end
        end
        S_TRAIL: begin
          if (dly == '0) begin
            st <= keep_q ? S_HOLD : S_IDLE;
            if (!keep_q) cs_n_q <= '1;
          end else dly <= dly - 8'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sck_o      = sck_q;
  assign mosi_o     = txsr[15];
  assign cs_n_o     = cs_n_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign rx_perr_o  = rx_perr_q;

  a_r5_idle_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_IDLE) |-> (&cs_n_q));
  a_r2_sck_quiet_trail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_TRAIL) |=> $stable(sck_q));
  a_r2_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_SHIFT) |-> (edge_q < {nbits_q, 1'b0}));
  a_r10_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_q && !rx_ready_i) |=> (rx_valid_q && $stable(rx_data_q) && $stable(rx_perr_q)));
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int NUM_ATTR = 2,
  parameter int NCS      = 8,
  parameter int CNT_W    = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic [31:0]           cmd_data_i,
  output logic                  rx_valid_o,
  input  logic                  rx_ready_i,
  output logic [15:0]           rx_data_o,
  output logic                  rx_perr_o,
  output logic                  sck_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic [NCS-1:0]        cs_n_o,
  input  logic                  halt_i,
  input  logic [1:0]            flag_clr_i,
  output logic                  eoq_flag_o,
  output logic                  perr_flag_o,
  output logic [CNT_W-1:0]      xfer_cnt_o,
  input  logic [NUM_ATTR*5-1:0] attr_size_i,
  input  logic [NUM_ATTR-1:0]   attr_cpol_i,
  input  logic [NUM_ATTR-1:0]   attr_cpha_i,
  input  logic [NUM_ATTR*8-1:0] attr_div_i,
  input  logic [NUM_ATTR*8-1:0] attr_lead_i,
  input  logic [NUM_ATTR*8-1:0] attr_trail_i
);
  cmd_t  cmd;
  attr_t attr;
  logic  start_clr, done, done_eoq, perr_pulse;
  logic  eoq_flag_q, perr_flag_q;
  logic [CNT_W-1:0] cnt_q;

  assign cmd = cmd_t'(cmd_data_i);

  spi_attr_pick #(.NUM_ATTR(NUM_ATTR)) u_pick (
    .size_i (attr_size_i),
    .cpol_i (attr_cpol_i),
    .cpha_i (attr_cpha_i),
    .div_i  (attr_div_i),
    .lead_i (attr_lead_i),
    .trail_i(attr_trail_i),
    .idx_i  (cmd.aidx),
    .attr_o (attr)
  );

  spi_frame_core #(.NCS(NCS)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_i       (cmd),
    .attr_i      (attr),
    .halt_i      (halt_i),
    .rx_ready_i  (rx_ready_i),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o),
    .rx_perr_o   (rx_perr_o),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .miso_i      (miso_i),
    .cs_n_o      (cs_n_o),
    .start_clr_o (start_clr),
    .done_o      (done),
    .done_eoq_o  (done_eoq),
    .perr_pulse_o(perr_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; eoq_flag_q <= 1'b0; perr_flag_q <= 1'b0;
    end else begin
      if (start_clr) cnt_q <= '0;                   // R9
      else if (done) cnt_q <= cnt_q + 1'b1;
      eoq_flag_q  <= (eoq_flag_q & ~flag_clr_i[0]) | (done & done_eoq);   // R8
      perr_flag_q <= (perr_flag_q & ~flag_clr_i[1]) | perr_pulse;         // R7
    end
  end

  assign xfer_cnt_o  = cnt_q;
  assign eoq_flag_o  = eoq_flag_q;
  assign perr_flag_o = perr_flag_q;

  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !start_clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr |=> (cnt_q == '0));
  a_r8_eoq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && done_eoq) |=> eoq_flag_q);
  a_r7_perr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_pulse |=> perr_flag_q);
endmodule

// File: tb/spi_cmd_master_tb.sv
module spi_cmd_master_tb;
  localparam int NA = 2;
  localparam int NC = 8;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, rx_valid, rx_ready = 1'b1, rx_perr;
  logic [31:0] cmd_data = '0;
  logic [15:0] rx_data;
  logic sck, mosi, miso = 1'b0, halt = 1'b0, eoq_flag, perr_flag;
  logic [NC-1:0] cs_n;
  logic [1:0] flag_clr = '0;
  logic [CW-1:0] xcnt;
  logic [NA*5-1:0] a_size;
  logic [NA-1:0] a_cpol, a_cpha;
  logic [NA*8-1:0] a_div, a_lead, a_trail;

  int checks = 0, fails = 0, exp_cnt = 0;
  bit exp_eoq = 0, exp_perr = 0, finished = 0;

  always #5 clk = ~clk;

  spi_cmd_master #(.NUM_ATTR(NA), .NCS(NC), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_data_i(cmd_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_data_o(rx_data), .rx_perr_o(rx_perr), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_n_o(cs_n), .halt_i(halt), .flag_clr_i(flag_clr),
    .eoq_flag_o(eoq_flag), .perr_flag_o(perr_flag), .xfer_cnt_o(xcnt),
    .attr_size_i(a_size), .attr_cpol_i(a_cpol), .attr_cpha_i(a_cpha),
    .attr_div_i(a_div), .attr_lead_i(a_lead), .attr_trail_i(a_trail));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_attr(input int s, input int n, input bit pol, input bit pha,
                          input int dv, input int ld, input int tr);
    a_size[s*5 +: 5] = 5'(n); a_cpol[s] = pol; a_cpha[s] = pha;
    a_div[s*8 +: 8] = 8'(dv); a_lead[s*8 +: 8] = 8'(ld); a_trail[s*8 +: 8] = 8'(tr);
  endtask

  // R1 layout: keep[31] idx[30:28] eoq[27] clr[26] pen[25] podd[24] line i at [23-i] data[15:0]
  function automatic logic [31:0] mk(input bit keep, input int idx, input bit eoq, input bit clr,
                                     input bit pen, input bit podd, input logic [7:0] lines,
                                     input logic [15:0] data);
    logic [31:0] w;
    w = {keep, 3'(idx), eoq, clr, pen, podd, 8'h00, data};
    for (int i = 0; i < 8; i++) w[23-i] = lines[i];
    return w;
  endfunction

  task automatic do_frame(input logic [31:0] cmd, input logic [15:0] pat, input int n,
                          input bit pol, input bit pha, input int ld, input int tr, input int dv);
    bit keep, pen, podd, got;
    logic [7:0] lines;
    logic [15:0] mask, dl, cap, rxd;
    bit rxp, prev, perr_exp;
    int k, cyc, edges, first, last;
    keep = cmd[31]; pen = cmd[25]; podd = cmd[24];
    for (int i = 0; i < 8; i++) lines[i] = cmd[23-i];
    mask = 16'((32'd1 << n) - 1);
    dl = cmd[15:0] & mask;
    if (pen) dl[0] = (^(dl >> 1)) ^ podd;
    perr_exp = pen && ((^(pat & mask)) != podd);
    k = 0; got = 0; cap = '0; rxd = '0; rxp = 0;
    miso = pat[n-1];
    @(negedge clk); cmd_valid = 1'b1; cmd_data = cmd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
    chk(cs_n == NC'(~lines), "R4", "select level at frame start", int'(cs_n), int'(NC'(~lines)));
    chk(sck == pol, "R2", "idle sck level", int'(sck), int'(pol));
    cyc = 0; edges = 0; first = -1; last = -1; prev = sck;
    while (!cmd_ready && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (sck != prev) begin
        if (pha ? (edges % 2 == 1) : (edges % 2 == 0)) begin
          cap = {cap[14:0], mosi}; k++;
          if (k < n) miso = pat[n-1-k];
        end
        edges++;
        if (first < 0) first = cyc;
        last = cyc; prev = sck;
      end
      if (rx_valid) begin got = 1; rxd = rx_data; rxp = rx_perr; end
    end
    chk(edges == 2*n, "R2", "sck edge count", edges, 2*n);
    chk((cap & mask) == dl, "R6", "mosi word (R2 order)", int'(cap & mask), int'(dl));
    if (pen) chk((^(cap & mask)) == podd, "R6", "tx parity sense", int'(^(cap & mask)), int'(podd));
    chk(first == ld + dv + 1, "R4", "lead gap", first, ld + dv + 1);
    chk(cyc - last == tr + 2, "R4", "trail gap", cyc - last, tr + 2);
    chk(got && rxd == (pat & mask), "R2", "rx word", int'(rxd), int'(pat & mask));
    chk(rxp == perr_exp, "R7", "rx parity flag", int'(rxp), int'(perr_exp));
    chk(cs_n == (keep ? NC'(~lines) : '1), "R5", "select after frame", int'(cs_n),
        int'(keep ? NC'(~lines) : '1));
    exp_cnt = cmd[26] ? 1 : (exp_cnt + 1) % (1 << CW);
    chk(int'(xcnt) == exp_cnt, "R9", "frame count", int'(xcnt), exp_cnt);
    if (cmd[27]) exp_eoq = 1;
    if (perr_exp) exp_perr = 1;
    chk(eoq_flag == exp_eoq, "R8", "eoq flag", int'(eoq_flag), int'(exp_eoq));
    chk(perr_flag == exp_perr, "R7", "perr flag", int'(perr_flag), int'(exp_perr));
  endtask

  task automatic send_only(input logic [31:0] cmd);
    @(negedge clk); cmd_valid = 1'b1; cmd_data = cmd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int sizes [4] = '{4, 7, 8, 16};
    int i;
    set_attr(0, 8, 0, 0, 1, 0, 0);
    set_attr(1, 5, 1, 1, 2, 2, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == '1 && sck == 1'b0 && !rx_valid, "R4", "reset pins", int'(cs_n), 255);
    chk(cmd_ready && !eoq_flag && !perr_flag && xcnt == '0, "R9", "reset status", int'(xcnt), 0);

    // Sweep: every mode, four sizes, parity off/even/odd (R1 R2 R6 R7 R9 wrap)
    i = 0;
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 3; p++) begin
          set_attr(0, sizes[s], m[1], m[0], 1 + i % 2, i % 3, i % 4);
          do_frame(mk(0, 0, i % 5 == 0, i == 20, p != 0, p == 2, 8'(1 << (i % 8)),
                      16'hA5C3 ^ 16'(i * 16'h1357)),
                   16'h3C96 ^ 16'(i * 16'h2B1D), sizes[s], m[1], m[0], i % 3, i % 4, 1 + i % 2);
          i++;
        end

    // R8 write-1 clear of both flags
    @(negedge clk); flag_clr = 2'b11; @(negedge clk); flag_clr = 2'b00;
    exp_eoq = 0; exp_perr = 0;
    chk(!eoq_flag && !perr_flag, "R8", "flags cleared", int'({eoq_flag, perr_flag}), 0);

    // R3: index 1 uses set 1; indices 2 and 7 fall back to set 0
    set_attr(0, 8, 0, 0, 1, 1, 1);
    do_frame(mk(0, 1, 1, 0, 0, 0, 8'h10, 16'h00B6), 16'h0013, 5, 1, 1, 2, 0, 2);
    do_frame(mk(0, 7, 0, 0, 0, 0, 8'h20, 16'h5A3C), 16'h00E1, 8, 0, 0, 1, 1, 1);
    do_frame(mk(0, 2, 0, 0, 1, 1, 8'h40, 16'h1234), 16'h0077, 8, 0, 0, 1, 1, 1);

    // R5: keep-select holds across an empty queue, released by a plain frame
    do_frame(mk(1, 0, 0, 0, 0, 0, 8'h81, 16'h00F0), 16'h0055, 8, 0, 0, 1, 1, 1);
    repeat (10) @(negedge clk);
    chk(cs_n == NC'(~8'h81), "R5", "hold while queue empty", int'(cs_n), int'(NC'(~8'h81)));
    do_frame(mk(0, 0, 0, 0, 0, 0, 8'h02, 16'h000F), 16'h00AA, 8, 0, 0, 1, 1, 1);
    // R5: halt releases held selects on the next clock
    do_frame(mk(1, 0, 0, 0, 0, 0, 8'h0C, 16'h0033), 16'h0011, 8, 0, 0, 1, 1, 1);
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    chk(cs_n == '1, "R5", "halt release", int'(cs_n), 255);

    // R10: back-pressure on the receive stream stalls the next frame
    rx_ready = 1'b0; miso = 1'b1;
    send_only(mk(0, 0, 0, 0, 0, 0, 8'h01, 16'h0001));
    repeat (60) @(negedge clk);
    chk(rx_valid && rx_data == 16'h00FF, "R10", "first word waiting", int'(rx_data), 16'h00FF);
    set_attr(0, 4, 0, 0, 1, 0, 0);
    send_only(mk(0, 0, 0, 0, 0, 0, 8'h01, 16'h0001));
    repeat (60) @(negedge clk);
    chk(!cmd_ready, "R10", "engine stalled", int'(cmd_ready), 0);
    chk(rx_valid && rx_data == 16'h00FF, "R10", "first word kept", int'(rx_data), 16'h00FF);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(rx_valid && rx_data == 16'h000F, "R10", "second word follows", int'(rx_data), 16'h000F);
    repeat (10) @(negedge clk);
    chk(cmd_ready && cs_n == '1, "R10", "engine resumes", int'(cmd_ready), 1);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule